// File: doc/BRIEF.md
# Instruction Fetch Execution Guard

The guard sits between a small 32-bit CPU and its memory read-data path. On every instruction fetch it compares the fetch address against two forbidden regions. The first region is fixed and covers the firmware RAM. The second is a no-execute window that software programs through a small register port. When a fetch lands in a forbidden region, the guard hands the CPU an illegal instruction word instead of the memory word. The CPU then takes its trap, and only a full reset gets it out of that state. Data reads pass through untouched, whatever their address.

Software writes the lower and upper bounds of the window, then writes the control register to arm it. Arming cannot be undone: after it, writes to the bound registers and to the control register have no effect until reset. A lock state machine holds this. It has two states, `WIN_OPEN` (after reset; the bounds are writable and the window is not checked) and `WIN_ARMED` (the window is checked and the bounds are frozen). There is one transition, `WIN_OPEN -> WIN_ARMED`, taken on any write to the control register. There is no transition out of `WIN_ARMED`.

The guard also watches the CPU's trap indication and flashes a red LED while the trap is asserted. An LED state machine has two states, `LED_DARK` and `LED_LIT`. While the trap is high, a counter of `LED_DIV_LOG2` bits counts clock cycles. Each time the counter wraps, the machine moves `LED_DARK -> LED_LIT` or `LED_LIT -> LED_DARK`. When the trap is low, the machine returns to `LED_DARK` and the counter clears.

Top module: `xguard_top`

## Requirements
- R1: A fetch (`fetch_valid`=1) whose address lies in `FW_BASE` .. `FW_BASE+FW_BYTES-1`, both ends inclusive, always returns the illegal word, whatever the register settings. Fetches just outside those bounds return `mem_rdata`.
- R2: When `fetch_valid`=0, `cpu_rdata` equals `mem_rdata` for every address, including the firmware range and an armed window.
- R3: A write with `cfg_addr`=0 loads the window's first address, and a write with `cfg_addr`=1 loads its last address. While the window is not armed, a fetch inside these bounds returns `mem_rdata`.
- R4: A write with `cfg_addr`=2, carrying any data, arms the window. From the next cycle on, a fetch with first <= addr <= last (unsigned, inclusive) returns the illegal word, and a fetch one word outside either bound returns `mem_rdata`.
- R5: Arming is permanent. A later write to `cfg_addr`=2, even with data 0, leaves the window armed.
- R6: Once the window is armed, writes to `cfg_addr`=0 and `cfg_addr`=1 are ignored, and the original bounds stay in force.
- R7: The substituted illegal instruction word is 32'h00000000.
- R8: When `cpu_trap` is low, `led_red` is 0 from the next clock edge on. When `cpu_trap` has been high for 2^`LED_DIV_LOG2` consecutive rising edges, `led_red` turns on. It then toggles every 2^`LED_DIV_LOG2` edges while the trap stays high.
- R9: After reset, the window is disarmed and `led_red` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word index (0 first, 1 last, 2 control) |
| cfg_wdata | input | ADDR_W | Register write data |
| fetch_valid | input | 1 | The current access is an instruction fetch |
| mem_addr | input | ADDR_W | CPU access address |
| mem_rdata | input | ADDR_W | Read data from memory |
| cpu_rdata | output | ADDR_W | Read data delivered to the CPU |
| cpu_trap | input | 1 | CPU is in its trap state |
| led_red | output | 1 | Red status LED |

## Verification
The assertions assume that the access address and the memory data come from the same cycle, and that `fetch_valid` marks that cycle's access as a fetch. The bench always sets the address, the data and the fetch flag together on the falling edge and samples before the next rising edge. The LED properties assume that `cpu_trap` changes only between clock edges. The bench drives the trap on the falling edge and holds it for whole cycles. The lock properties assume the register port is written one word per cycle with a clean strobe. The bench's write task drives the strobe for exactly one rising edge.

// File: rtl/xg_pkg.sv
package xg_pkg;
    typedef enum logic {WIN_OPEN = 1'b0, WIN_ARMED = 1'b1} lock_state_t;
    typedef enum logic {LED_DARK = 1'b0, LED_LIT = 1'b1} led_state_t;
    localparam logic [31:0] ILLEGAL_WORD = 32'h0000_0000;
    localparam int REG_FIRST = 0;
    localparam int REG_LAST  = 1;
    localparam int REG_CTRL  = 2;
endpackage

// File: rtl/xg_window_regs.sv
module xg_window_regs
    import xg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CFG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] win_first,
    output logic [ADDR_W-1:0] win_last,
    output logic              win_armed
);
    localparam logic [CFG_AW-1:0] A_FIRST = CFG_AW'(REG_FIRST);
    localparam logic [CFG_AW-1:0] A_LAST  = CFG_AW'(REG_LAST);
    localparam logic [CFG_AW-1:0] A_CTRL  = CFG_AW'(REG_CTRL);

    lock_state_t state_q, state_d;
    logic        wr_first, wr_last, wr_ctrl;

    always_comb begin
        wr_first = cfg_we && (cfg_addr == A_FIRST);
        wr_last  = cfg_we && (cfg_addr == A_LAST);
        wr_ctrl  = cfg_we && (cfg_addr == A_CTRL);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OPEN:  if (wr_ctrl) state_d = WIN_ARMED;
            WIN_ARMED: state_d = WIN_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_first <= '0;
            win_last  <= '0;
        end else if (state_q == WIN_OPEN) begin
            if (wr_first) win_first <= cfg_wdata;
            if (wr_last)  win_last  <= cfg_wdata;
        end
    end

    always_comb win_armed = (state_q == WIN_ARMED);

    // R5: no way back from armed
    a_r5_armed_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        win_armed |=> win_armed);
    // R6: bounds frozen once armed
    a_r6_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        win_armed |=> ($stable(win_first) && $stable(win_last)));
    // R4: control write arms next cycle
    a_r4_ctrl_arms: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> win_armed);
endmodule

// File: rtl/xg_range_check.sv
module xg_range_check #(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/xg_led_flasher.sv
module xg_led_flasher
    import xg_pkg::*;
#(
    parameter int LED_DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trap,
    output logic led
);
    localparam logic [LED_DIV_LOG2-1:0] CNT_TOP = '1;

    led_state_t               state_q, state_d;
    logic [LED_DIV_LOG2-1:0]  cnt_q;
    logic                     wrap;

    always_comb wrap = (cnt_q == CNT_TOP);

    always_comb begin
        state_d = state_q;
        if (!trap) begin
            state_d = LED_DARK;
        end else begin
            unique case (state_q)
                LED_DARK: if (wrap) state_d = LED_LIT;
                LED_LIT:  if (wrap) state_d = LED_DARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LED_DARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= trap ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb led = (state_q == LED_LIT);

    // R8: dark whenever trap was low at the last edge
    a_r8_dark_untrapped: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |=> !led);
    // R8: LED lights only under trap
    a_r8_lit_needs_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led) |-> $past(trap));
endmodule

// File: rtl/xguard_top.sv
module xguard_top
    import xg_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter int              CFG_AW       = 2,
    parameter logic [31:0]     FW_BASE      = 32'hD000_0000,
    parameter logic [31:0]     FW_BYTES     = 32'h0000_0800,
    parameter int              LED_DIV_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] cpu_rdata,
    input  logic              cpu_trap,
    output logic              led_red
);
    localparam logic [ADDR_W-1:0] FW_LO = ADDR_W'(FW_BASE);
    localparam logic [ADDR_W-1:0] FW_HI = ADDR_W'(FW_BASE + FW_BYTES - 32'd1);

    logic [ADDR_W-1:0] win_first, win_last;
    logic              win_armed, fw_hit, win_hit, block;

    xg_window_regs #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .win_first(win_first), .win_last(win_last),
        .win_armed(win_armed)
    );

    xg_range_check #(.ADDR_W(ADDR_W)) u_fw_chk (
        .en(1'b1), .lo(FW_LO), .hi(FW_HI), .addr(mem_addr), .hit(fw_hit)
    );

    xg_range_check #(.ADDR_W(ADDR_W)) u_win_chk (
        .en(win_armed), .lo(win_first), .hi(win_last), .addr(mem_addr),
        .hit(win_hit)
    );

    always_comb begin
        block     = fetch_valid && (fw_hit || win_hit);
        cpu_rdata = block ? ADDR_W'(ILLEGAL_WORD) : mem_rdata;
    end

    xg_led_flasher #(.LED_DIV_LOG2(LED_DIV_LOG2)) u_led (
        .clk(clk), .rst_n(rst_n), .trap(cpu_trap), .led(led_red)
    );

    // R2: data reads pass through
    a_r2_data_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (cpu_rdata == mem_rdata));
    // R1/R7: firmware RAM fetch yields illegal word
    a_r1_fw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && mem_addr >= FW_LO && mem_addr <= FW_HI)
            |-> (cpu_rdata == ADDR_W'(ILLEGAL_WORD)));
    // R9: disarmed straight after reset
    a_r9_reset_open: assert property (@(posedge clk)
        $rose(rst_n) |-> !win_armed);
endmodule

// File: tb/xguard_top_test.sv
module xguard_top_test;
    localparam logic [31:0] FWB = 32'hD000_0000;
    localparam logic [31:0] FWN = 32'h0000_0800;
    localparam int          NDIV = 4;
    localparam int          PER  = 1 << NDIV;

    logic        clk = 0, rst_n = 0, cfg_we = 0, fetch_valid = 0, cpu_trap = 0;
    logic [1:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0, mem_addr = 0, mem_rdata = 0;
    logic [31:0] cpu_rdata;
    logic        led_red;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xguard_top #(.FW_BASE(FWB), .FW_BYTES(FWN), .LED_DIV_LOG2(NDIV)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata), .cpu_trap(cpu_trap),
        .led_red(led_red)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic access(string req, logic f, logic [31:0] a, logic [31:0] exp_blk);
        logic [31:0] word;
        @(negedge clk);
        word = a ^ 32'h5A5A_1234;
        fetch_valid = f; mem_addr = a; mem_rdata = word;
        #1;
        check(req, cpu_rdata, exp_blk ? 32'h0 : word);
        fetch_valid = 0;
    endtask

    task automatic t_reset;
        #1;
        check("R9 led after reset", {31'b0, led_red}, 0);
        access("R9 window disarmed", 1, 32'h4000_0000, 0);
    endtask

    task automatic t_firmware;
        access("R1 fw low bound", 1, FWB, 1);
        access("R1 fw high bound", 1, FWB + FWN - 4, 1);
        access("R1 fw last byte", 1, FWB + FWN - 1, 1);
        access("R1 below fw", 1, FWB - 4, 0);
        access("R1 above fw", 1, FWB + FWN, 0);
        access("R2 data read fw", 0, FWB + 32'h10, 0);
    endtask

    task automatic t_window_open;
        wr(0, 32'h4000_0100);
        wr(1, 32'h4000_01FC);
        access("R3 open window fetch", 1, 32'h4000_0100, 0);
        access("R3 open window mid", 1, 32'h4000_0150, 0);
    endtask

    task automatic t_arm;
        wr(2, 32'h0000_0001);
        access("R4 first bound", 1, 32'h4000_0100, 1);
        access("R4 last bound", 1, 32'h4000_01FC, 1);
        access("R4 below first", 1, 32'h4000_00FC, 0);
        access("R4 above last", 1, 32'h4000_0200, 0);
        access("R2 data in window", 0, 32'h4000_0150, 0);
        @(negedge clk);
        fetch_valid = 1; mem_addr = 32'h4000_0150; mem_rdata = 32'hFFFF_FFFF;
        #1;
        check("R7 illegal word", cpu_rdata, 32'h0000_0000);
        fetch_valid = 0;
    endtask

    task automatic t_locked;
        wr(0, 32'h4000_0000);
        wr(1, 32'h4000_0010);
        access("R6 new bounds ignored", 1, 32'h4000_0008, 0);
        access("R6 old bounds kept", 1, 32'h4000_0150, 1);
        wr(2, 32'h0);
        access("R5 still armed", 1, 32'h4000_0180, 1);
    endtask

    task automatic t_led;
        @(negedge clk);
        cpu_trap = 1;
        repeat (PER - 1) @(posedge clk);
        @(negedge clk);
        check("R8 dark before period", {31'b0, led_red}, 0);
        @(posedge clk); @(negedge clk);
        check("R8 lit after period", {31'b0, led_red}, 1);
        repeat (PER - 1) @(posedge clk);
        @(negedge clk);
        check("R8 lit until next wrap", {31'b0, led_red}, 1);
        @(posedge clk); @(negedge clk);
        check("R8 toggles off", {31'b0, led_red}, 0);
        repeat (PER) @(posedge clk);
        @(negedge clk);
        check("R8 toggles on again", {31'b0, led_red}, 1);
        cpu_trap = 0;
        @(posedge clk); @(negedge clk);
        check("R8 dark when untrapped", {31'b0, led_red}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_firmware();
        t_window_open();
        t_arm();
        t_locked();
        t_led();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule